// File: doc/BRIEF.md
# Byte Bit-Manipulation Execution Unit

This unit executes single-bit operations on one byte for a small 16-bit processor core. Each request carries an operation code, the byte to work on, and a bit number. The bit number comes either from a 3-bit immediate field or from the low three bits of a register value. The request also carries the current zero (Z) and carry (C) flags. The unit returns the resulting byte, a write-back enable, the new Z and C flags, and an illegal-operation indication.

Set, clear and invert produce a modified byte to write back. Test copies the complement of the chosen bit into Z. The four carry operations fold the chosen bit, or its complement, into C with AND or OR.

Requests enter through a valid/ready stream and results leave through another. One pipeline register sits between them. The input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty, or when its current result is being taken in the same cycle (`out_ready` high). A result stays on the output, unchanged, until `out_ready` is seen high while `out_valid` is high.

Top module: `bitman_unit`

## Requirements
- R1: Opcode 0 (set) and opcode 1 (clear) force the selected bit of the byte to 1 or to 0. All other bits pass through unchanged. `out_we` is 1, and Z and C are unchanged.
- R2: Opcode 2 (invert) complements only the selected bit. `out_we` is 1, and Z and C are unchanged.
- R3: Opcode 3 (test) sets Z to the complement of the selected bit. `out_we` is 0, C is unchanged, and the byte passes through.
- R4: Opcode 4 sets C to C AND bit, and opcode 5 sets C to C AND NOT bit. Z is unchanged, `out_we` is 0, and the byte passes through.
- R5: Opcode 6 sets C to C OR bit, and opcode 7 sets C to C OR NOT bit. Z is unchanged, `out_we` is 0, and the byte passes through.
- R6: With `in_use_reg`=1 the bit number is `in_reg[2:0]`, and `in_reg[15:3]` has no effect. With `in_use_reg`=0 the bit number is `in_imm`.
- R7: Opcodes 5 and 7 with `in_use_reg`=1 raise `out_illegal`. In that case `out_we` is 0, and Z, C and the byte are unchanged.
- R8: Opcodes 8 to 15 raise `out_illegal`, with `out_we` 0, Z, C and the byte unchanged. Legal requests give `out_illegal`=0.
- R9: An accepted request gives `out_valid`=1 on the next clock. `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid`=1 and `out_ready`=0, the outputs hold stable.
- R10: Synchronous reset `rst` clears `out_valid` on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request this cycle |
| in_op | input | 4 | Operation code |
| in_data | input | 8 | Operand byte |
| in_imm | input | 3 | Immediate bit number |
| in_use_reg | input | 1 | 1: bit number from `in_reg`, 0: from `in_imm` |
| in_reg | input | 16 | Register value supplying the bit number |
| in_z | input | 1 | Current Z flag |
| in_c | input | 1 | Current C flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 8 | Resulting byte |
| out_we | output | 1 | Write-back enable |
| out_z | output | 1 | New Z flag |
| out_c | output | 1 | New C flag |
| out_illegal | output | 1 | Illegal operation or bit-number source |

## Verification
The hardest case to reach is a result held under back-pressure while a new request is already waiting. The output must keep its old value, and the waiting request must go in on exactly the cycle the consumer drains the result. The stimulus produces this by dropping `out_ready` for random runs of cycles while `in_valid` stays high. A second hard case is a register-sourced request for the inverse carry operations. Here only the illegal flag may change, and the incoming Z and C must come back untouched. Both flag values are therefore varied on those requests. Register values are given random upper bits, so that any dependence on bits above the low three shows up.

// File: rtl/bitman_pkg.sv
package bitman_pkg;
  localparam int unsigned BM_DW = 8;
  localparam int unsigned BM_IW = $clog2(BM_DW);

  typedef enum logic [3:0] {
    OP_SET  = 4'd0,
    OP_CLR  = 4'd1,
    OP_INV  = 4'd2,
    OP_TST  = 4'd3,
    OP_AND  = 4'd4,
    OP_ANDN = 4'd5,
    OP_OR   = 4'd6,
    OP_ORN  = 4'd7
  } bm_op_e;

  typedef struct packed {
    logic [BM_DW-1:0] data;
    logic             we;
    logic             z;
    logic             c;
    logic             illegal;
  } bm_res_t;
endpackage

// File: rtl/bitman_sel.sv
module bitman_sel #(
  parameter int unsigned DW    = 8,
  parameter int unsigned REG_W = 16,
  localparam int unsigned IW   = $clog2(DW)
) (
  input  logic [IW-1:0]    imm,
  input  logic             use_reg,
  input  logic [REG_W-1:0] reg_val,
  output logic [DW-1:0]    mask
);
  logic [IW-1:0] idx;

  // Only the low index bits of the register take part in selection.
  assign idx = use_reg ? reg_val[IW-1:0] : imm;

  for (genvar g = 0; g < DW; g++) begin : g_mask
    assign mask[g] = (idx == IW'(g));
  end
endmodule

// File: rtl/bitman_alu.sv
module bitman_alu
  import bitman_pkg::*;
(
  input  logic [3:0]       op,
  input  logic             use_reg,
  input  logic [BM_DW-1:0] operand,
  input  logic [BM_DW-1:0] mask,
  input  logic             z_in,
  input  logic             c_in,
  output bm_res_t          res
);
  logic sel_bit;

  assign sel_bit = |(operand & mask);

  always_comb begin
    res.data    = operand;
    res.we      = 1'b0;
    res.z       = z_in;
    res.c       = c_in;
    res.illegal = 1'b0;
    case (op)
      OP_SET: begin res.data = operand | mask;  res.we = 1'b1; end
      OP_CLR: begin res.data = operand & ~mask; res.we = 1'b1; end
      OP_INV: begin res.data = operand ^ mask;  res.we = 1'b1; end
      OP_TST: res.z = ~sel_bit;
      OP_AND: res.c = c_in & sel_bit;
      OP_OR:  res.c = c_in | sel_bit;
      OP_ANDN: begin
        if (use_reg) res.illegal = 1'b1;
        else         res.c = c_in & ~sel_bit;
      end
      OP_ORN: begin
        if (use_reg) res.illegal = 1'b1;
        else         res.c = c_in | ~sel_bit;
      end
      default: res.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/bitman_stage.sv
module bitman_stage
  import bitman_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    s_valid,
  output logic    s_ready,
  input  bm_res_t s_res,
  output logic    m_valid,
  input  logic    m_ready,
  output bm_res_t m_res
);
  logic vld_q;

  assign s_ready = ~vld_q | m_ready;
  assign m_valid = vld_q;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else if (s_ready) vld_q <= s_valid;
  end

  always_ff @(posedge clk) begin
    if (s_valid && s_ready) m_res <= s_res;
  end
endmodule

// File: rtl/bitman_unit.sv
module bitman_unit
  import bitman_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic [BM_DW-1:0] in_data,
  input  logic [BM_IW-1:0] in_imm,
  input  logic             in_use_reg,
  input  logic [REG_W-1:0] in_reg,
  input  logic             in_z,
  input  logic             in_c,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BM_DW-1:0] out_data,
  output logic             out_we,
  output logic             out_z,
  output logic             out_c,
  output logic             out_illegal
);
  logic [BM_DW-1:0] mask;
  bm_res_t          comb_res;
  bm_res_t          reg_res;

  bitman_sel #(.DW(BM_DW), .REG_W(REG_W)) u_sel (
    .imm(in_imm), .use_reg(in_use_reg), .reg_val(in_reg), .mask(mask)
  );

  bitman_alu u_alu (
    .op(in_op), .use_reg(in_use_reg), .operand(in_data), .mask(mask),
    .z_in(in_z), .c_in(in_c), .res(comb_res)
  );

  bitman_stage u_stage (
    .clk(clk), .rst(rst),
    .s_valid(in_valid), .s_ready(in_ready), .s_res(comb_res),
    .m_valid(out_valid), .m_ready(out_ready), .m_res(reg_res)
  );

  assign out_data    = reg_res.data;
  assign out_we      = reg_res.we;
  assign out_z       = reg_res.z;
  assign out_c       = reg_res.c;
  assign out_illegal = reg_res.illegal;
endmodule

// File: rtl/bitman_chk.sv
module bitman_chk #(
  parameter int unsigned REG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_op,
  input logic             in_use_reg,
  input logic             in_z,
  input logic             in_c,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_we,
  input logic             out_z,
  input logic             out_c,
  input logic             out_illegal
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !out_valid); // R10
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid); // R9
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_we)
      && $stable(out_z) && $stable(out_c) && $stable(out_illegal)); // R9
  AST_SETCLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    acc && (in_op == 4'd0 || in_op == 4'd1) |=> out_we && out_z == $past(in_z)
      && out_c == $past(in_c)); // R1
  AST_TEST_NO_WB: assert property (@(posedge clk) disable iff (rst)
    acc && in_op == 4'd3 |=> !out_we && out_c == $past(in_c)); // R3
  AST_CARRY_KEEPS_Z: assert property (@(posedge clk) disable iff (rst)
    acc && in_op[3:2] == 2'b01 |=> !out_we && out_z == $past(in_z)); // R4
  AST_INV_REG_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    acc && in_use_reg && (in_op == 4'd5 || in_op == 4'd7) |=> out_illegal
      && out_c == $past(in_c)); // R7
  AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> !out_we); // R8
endmodule

bind bitman_unit bitman_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_use_reg(in_use_reg), .in_z(in_z), .in_c(in_c),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_we(out_we), .out_z(out_z), .out_c(out_c), .out_illegal(out_illegal)
);

// File: tb/tb_bitman_unit.sv
module tb_bitman_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_use_reg = 1'b0, in_z = 1'b0, in_c = 1'b0;
  logic out_ready = 1'b1;
  logic [3:0] in_op = '0;
  logic [7:0] in_data = '0;
  logic [2:0] in_imm = '0;
  logic [15:0] in_reg = '0;
  logic in_ready, out_valid, out_we, out_z, out_c, out_illegal;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;

  // model state
  bit m_valid = 0;
  logic [11:0] m_vec = '0;
  string m_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  bitman_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_data(in_data), .in_imm(in_imm), .in_use_reg(in_use_reg),
    .in_reg(in_reg), .in_z(in_z), .in_c(in_c), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_we(out_we), .out_z(out_z),
    .out_c(out_c), .out_illegal(out_illegal)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: returns {data, we, z, c, illegal}
  function automatic logic [11:0] ref_op(input logic [3:0] op, input logic [7:0] d,
      input logic [2:0] imm, input logic ur, input logic [15:0] rv, input logic z, input logic c);
    int idx;
    logic [7:0] od;
    logic we, oz, oc, ill, b;
    idx = ur ? int'(rv % 16'd8) : int'(imm);
    b = d[idx];
    od = d; we = 0; oz = z; oc = c; ill = 0;
    case (op)
      4'd0: begin od[idx] = 1'b1; we = 1; end
      4'd1: begin od[idx] = 1'b0; we = 1; end
      4'd2: begin od[idx] = ~b; we = 1; end
      4'd3: oz = ~b;
      4'd4: oc = c && b;
      4'd5: if (ur) ill = 1; else oc = c && !b;
      4'd6: oc = c || b;
      4'd7: if (ur) ill = 1; else oc = c || !b;
      default: ill = 1;
    endcase
    return {od, we, oz, oc, ill};
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic ur);
    if (op > 4'd7) return "R8";
    if (ur && (op == 4'd5 || op == 4'd7)) return "R7";
    if (ur) return "R6";
    case (op)
      4'd0, 4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      default: return "R5";
    endcase
  endfunction

  // one clock: drive at negedge, predict, compare at following negedge
  task automatic step(input bit r, input bit v, input logic [3:0] op, input logic [7:0] d,
      input logic [2:0] imm, input logic ur, input logic [15:0] rv, input logic z,
      input logic c, input bit rdy);
    bit nv, acc;
    logic [11:0] nvec;
    string ntag;
    rst = r; in_valid = v; in_op = op; in_data = d; in_imm = imm;
    in_use_reg = ur; in_reg = rv; in_z = z; in_c = c; out_ready = rdy;
    #1;
    check("R9 in_ready", {11'd0, in_ready}, {11'd0, (!m_valid || rdy)});
    acc = v && (!m_valid || rdy);
    nv = m_valid; nvec = m_vec; ntag = m_tag;
    if (r) begin nv = 0; ntag = "R10"; end
    else if (acc) begin nv = 1; nvec = ref_op(op, d, imm, ur, rv, z, c); ntag = tag_of(op, ur); end
    else if (m_valid && rdy) nv = 0;
    @(posedge clk);
    #1;
    m_valid = nv; m_vec = nvec; m_tag = ntag;
    @(negedge clk);
    check({m_tag, " valid"}, {11'd0, out_valid}, {11'd0, m_valid});
    if (m_valid)
      check(m_tag, {out_data, out_we, out_z, out_c, out_illegal}, m_vec);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);            // R10 idle after reset
    // directed: every opcode on 8'hA5
    for (int o = 0; o < 16; o++) begin
      step(0, 1, 4'(o), 8'hA5, 3'd2, 0, 16'h0, 0, 1, 1);
      step(0, 1, 4'(o), 8'hA5, 3'd1, 0, 16'h0, 1, 0, 1);
    end
    // R6: register source with noisy upper bits, immediate disagrees
    for (int o = 0; o < 8; o++) begin
      step(0, 1, 4'(o), 8'h5A, 3'd0, 1, 16'hFFF9, 1, 1, 1);
      step(0, 1, 4'(o), 8'h5A, 3'd7, 1, 16'h0006, 0, 0, 1);
    end
    // R7: inverse carry ops with register source, all flag pairs
    for (int f = 0; f < 4; f++) begin
      step(0, 1, 4'd5, 8'h0F, 3'd4, 1, 16'h1234, f[1], f[0], 1);
      step(0, 1, 4'd7, 8'hF0, 3'd0, 1, 16'hABCD, f[1], f[0], 1);
    end
    // R9: stall with request waiting, then drain
    step(0, 1, 4'd0, 8'h00, 3'd3, 0, 0, 0, 0, 0);
    step(0, 1, 4'd1, 8'hFF, 3'd3, 0, 0, 0, 0, 0);
    step(0, 1, 4'd1, 8'hFF, 3'd3, 0, 0, 0, 0, 0);
    step(0, 1, 4'd1, 8'hFF, 3'd3, 0, 0, 0, 0, 1);
    step(0, 0, 4'd1, 8'hFF, 3'd3, 0, 0, 0, 0, 1);
    // random traffic with random back-pressure
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      step(0, a[0] | a[1], a[7:4], b[7:0], a[10:8], a[11], b[31:16],
           a[12], a[13], a[14] | a[15]);
    end
    // R10: reset while holding a stalled result
    step(0, 1, 4'd2, 8'h81, 3'd7, 0, 0, 0, 0, 0);
    step(1, 0, 4'd0, 8'h00, 3'd0, 0, 0, 0, 0, 0);
    step(0, 0, 4'd0, 8'h00, 3'd0, 0, 0, 0, 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule